// File: doc/BRIEF.md
# Multi-Source Reset Vector Controller

This block gathers every reason the processor core can be thrown back to its start address and turns them into one core reset with the start vector that matches the reason. The reasons are an active-low external reset pin, a break-instruction request, a watchdog overflow and an illegal-opcode trap. A digital supply-low flag is treated exactly like the pin, except while the device sits in stop mode with its clock halted.

The external pin is asynchronous, so it passes through a flop synchroniser. The three internal causes are single-cycle pulses from the core and the watchdog. When one or more causes fire, the core reset goes high on the next clock. The highest-priority cause picks the start vector and the one-hot cause record. The core stays in reset for as long as a level cause (pin or supply-low) is held.

Once every cause has gone away, the core reset drops. In the same cycle a one-cycle strobe tells the program counter to load the latched vector. The cause record keeps its value until the next reset is detected. The block's own asynchronous reset behaves like a pin reset: power-up ends with a vector-0 load.

Top module: `rstcause_top`

## Requirements
- R1: A single-cycle pulse on `brk_req`, `wdt_ovf` or `op_trap`, sampled on a rising edge, drives `core_rst` high after that edge. With no other cause present, `core_rst` stays high for exactly one cycle.
- R2: At the vector-load strobe, `start_vec` is 0x0000 for the pin or supply-low cause, 0x0002 for break, 0x0004 for watchdog overflow and 0x0006 for the opcode trap. `start_vec` is stable while the strobe is high.
- R3: When several causes are present in the same cycle, the winner is chosen in this order: pin or supply-low first, then watchdog, then opcode trap, then break. A pulse cause that arrives while a level cause is held does not change the recorded cause.
- R4: `ext_rst_n` goes through a two-stage synchroniser. After the pin goes low, `core_rst` rises after the third rising edge and stays high for as long as the pin stays low.
- R5: After the pin is released, `core_rst` falls after the third rising edge. In general, `core_rst` falls in the first cycle with no cause present. `pc_load` is high for exactly that one cycle, aligned with the fall of `core_rst`.
- R6: `supply_low` bypasses the synchroniser. It asserts `core_rst` after the next edge, holds it while high, and uses vector 0x0000.
- R7: While `stop_mode` is 1, `supply_low` has no effect on `core_rst`, `pc_load`, `cause` or `start_vec`.
- R8: `cause` is one-hot: bit 0 means pin or supply-low, bit 1 break, bit 2 watchdog, bit 3 opcode trap. It is written when a reset is detected and holds until the next detection.
- R9: While `arst_n` is low, the outputs read `core_rst`=1, `pc_load`=0, `cause`=0001 and `start_vec`=0. After `arst_n` is released with the pin high, `core_rst` falls together with a `pc_load` pulse after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block itself |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| supply_low | input | 1 | Digital supply-low flag, synchronous to `clk` |
| stop_mode | input | 1 | High while the device is stopped with its clock halted |
| brk_req | input | 1 | Break-instruction reset request, one-cycle pulse |
| wdt_ovf | input | 1 | Watchdog overflow, one-cycle pulse |
| op_trap | input | 1 | Illegal-opcode trap, one-cycle pulse |
| core_rst | output | 1 | Synchronous core reset, active high |
| pc_load | output | 1 | One-cycle strobe that loads `start_vec` into the program counter |
| start_vec | output | 16 | Start vector address chosen by the winning cause |
| cause | output | 4 | One-hot record of the cause of the last reset |

## Verification
The assertions assume that `brk_req`, `wdt_ovf` and `op_trap` are synchronous pulses that last one cycle. They also assume `supply_low` and `stop_mode` are already synchronous to `clk`. Only `ext_rst_n` may change at any time. The stimulus drives every input on the falling clock edge, raises each pulse cause for a single cycle, and changes only the pin at arbitrary cycle boundaries. Because of this, the one-cycle reset after a pulse and the one-cycle load strobe can be asserted without the assertions being affected by pulses that run into each other.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int NSRC = 4;

  // Source index doubles as vector slot and cause bit position
  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_BRK  = 2'd1,
    SRC_WDT  = 2'd2,
    SRC_TRAP = 2'd3
  } src_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } seq_e;
endpackage

// File: rtl/rstcause_sync.sv
module rstcause_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[LAST-1:0], async_in};
    end
  endgenerate

  // Reset value 0 means "pin seen low": power-up looks like a pin reset
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_out = chain_q[LAST];
endmodule

// File: rtl/rstcause_arb.sv
module rstcause_arb
  import rstcause_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_STRIDE = 2
) (
  input  logic             pin_lvl,
  input  logic             brk,
  input  logic             wdt,
  input  logic             trap,
  output logic             any,
  output logic [NSRC-1:0]  sel_oh,
  output logic [VEC_W-1:0] sel_vec
);
  logic [NSRC-1:0] raw;

  always_comb begin
    raw            = '0;
    raw[SRC_PIN]   = pin_lvl;
    raw[SRC_BRK]   = brk;
    raw[SRC_WDT]   = wdt;
    raw[SRC_TRAP]  = trap;
  end

  // Fixed priority: pin > watchdog > trap > break
  always_comb begin
    sel_oh = '0;
    if      (raw[SRC_PIN])  sel_oh[SRC_PIN]  = 1'b1;
    else if (raw[SRC_WDT])  sel_oh[SRC_WDT]  = 1'b1;
    else if (raw[SRC_TRAP]) sel_oh[SRC_TRAP] = 1'b1;
    else if (raw[SRC_BRK])  sel_oh[SRC_BRK]  = 1'b1;
  end

  assign any = |raw;

  // Vector of slot i is i * VEC_STRIDE
  logic [VEC_W-1:0] slot_vec [NSRC];
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_slot
      assign slot_vec[g] = VEC_W'(g * VEC_STRIDE);
    end
  endgenerate

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_oh[i]) sel_vec = sel_vec | slot_vec[i];
    end
  end
endmodule

// File: rtl/rstcause_seq.sv
module rstcause_seq
  import rstcause_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             any,
  input  logic             pulse_any,
  input  logic [NSRC-1:0]  sel_oh,
  input  logic [VEC_W-1:0] sel_vec,
  output logic             core_rst,
  output logic             pc_load,
  output logic [NSRC-1:0]  cause,
  output logic [VEC_W-1:0] vec
);
  localparam logic [NSRC-1:0] PIN_OH = NSRC'(1) << SRC_PIN;

  seq_e             st_q, st_d;
  logic             load_q, load_d;
  logic [NSRC-1:0]  cause_q, cause_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             cap_en;

  // Any detected cause (re)captures the record, in either state
  assign cap_en = any;

  always_comb begin
    st_d    = st_q;
    load_d  = 1'b0;
    cause_d = cause_q;
    vec_d   = vec_q;
    if (cap_en) begin
      st_d    = ST_HOLD;
      cause_d = sel_oh;
      vec_d   = sel_vec;
    end else if (st_q == ST_HOLD) begin
      st_d   = ST_RUN;
      load_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= ST_HOLD;
      load_q  <= 1'b0;
      cause_q <= PIN_OH;
      vec_q   <= '0;
    end else begin
      st_q   <= st_d;
      load_q <= load_d;
      if (cap_en) begin
        cause_q <= cause_d;
        vec_q   <= vec_d;
      end
    end
  end

  assign core_rst = (st_q == ST_HOLD);
  assign pc_load  = load_q;
  assign cause    = cause_q;
  assign vec      = vec_q;

  // R1
  pulse_rst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pulse_any |=> core_rst);

  // R5
  load_edge_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pc_load |-> (!core_rst && $past(core_rst)));

  // R5
  load_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pc_load |=> !pc_load);

  // R8
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(cause) == 1);

  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !any |=> $stable(cause));

  // R2
  vec_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pc_load |-> $stable(vec));
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
  import rstcause_pkg::*;
#(
  parameter int VEC_W       = 16,
  parameter int VEC_STRIDE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             ext_rst_n,
  input  logic             supply_low,
  input  logic             stop_mode,
  input  logic             brk_req,
  input  logic             wdt_ovf,
  input  logic             op_trap,
  output logic             core_rst,
  output logic             pc_load,
  output logic [VEC_W-1:0] start_vec,
  output logic [NSRC-1:0]  cause
);
  logic             pin_sync;
  logic             pin_lvl;
  logic             sup_ok;
  logic             any;
  logic             pulse_any;
  logic [NSRC-1:0]  sel_oh;
  logic [VEC_W-1:0] sel_vec;

  rstcause_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst_n   (arst_n),
    .async_in (ext_rst_n),
    .sync_out (pin_sync)
  );

  // Supply-low is gated off while the clock is halted in stop mode
  assign sup_ok    = supply_low & ~stop_mode;
  assign pin_lvl   = ~pin_sync | sup_ok;
  assign pulse_any = brk_req | wdt_ovf | op_trap;

  rstcause_arb #(.VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .pin_lvl (pin_lvl),
    .brk     (brk_req),
    .wdt     (wdt_ovf),
    .trap    (op_trap),
    .any     (any),
    .sel_oh  (sel_oh),
    .sel_vec (sel_vec)
  );

  rstcause_seq #(.VEC_W(VEC_W)) u_seq (
    .clk       (clk),
    .arst_n    (arst_n),
    .any       (any),
    .pulse_any (pulse_any),
    .sel_oh    (sel_oh),
    .sel_vec   (sel_vec),
    .core_rst  (core_rst),
    .pc_load   (pc_load),
    .cause     (cause),
    .vec       (start_vec)
  );

  // R7
  stop_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (stop_mode && pin_sync && !pulse_any) |=> !$rose(core_rst));

  // R3
  pin_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pin_lvl |=> (core_rst && cause[SRC_PIN]));
endmodule

// File: tb/rstcause_top_test.sv
module rstcause_top_test;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        ext_rst_n;
  logic        supply_low;
  logic        stop_mode;
  logic        brk_req;
  logic        wdt_ovf;
  logic        op_trap;
  logic        core_rst;
  logic        pc_load;
  logic [15:0] start_vec;
  logic [3:0]  cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rstcause_top uut (
    .clk(clk), .arst_n(arst_n), .ext_rst_n(ext_rst_n),
    .supply_low(supply_low), .stop_mode(stop_mode),
    .brk_req(brk_req), .wdt_ovf(wdt_ovf), .op_trap(op_trap),
    .core_rst(core_rst), .pc_load(pc_load),
    .start_vec(start_vec), .cause(cause)
  );

  // {brk, wdt, trap, supply_low, expected vector, expected one-hot cause}
  localparam int NV = 10;
  localparam logic [23:0] TBL [NV] = '{
    {4'b1000, 16'h0002, 4'b0010},
    {4'b0100, 16'h0004, 4'b0100},
    {4'b0010, 16'h0006, 4'b1000},
    {4'b0001, 16'h0000, 4'b0001},
    {4'b1100, 16'h0004, 4'b0100},
    {4'b0110, 16'h0004, 4'b0100},
    {4'b1010, 16'h0006, 4'b1000},
    {4'b1111, 16'h0000, 4'b0001},
    {4'b1001, 16'h0000, 4'b0001},
    {4'b1110, 16'h0004, 4'b0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; ext_rst_n = 1'b1; supply_low = 1'b0; stop_mode = 1'b0;
    brk_req = 1'b0; wdt_ovf = 1'b0; op_trap = 1'b0;
    tick(); tick();
    // R9 reset state
    chk("R9 core_rst in reset", 32'(core_rst), 32'd1);
    chk("R9 pc_load in reset", 32'(pc_load), 32'd0);
    chk("R9 cause in reset", 32'(cause), 32'b0001);
    chk("R9 vector in reset", 32'(start_vec), 32'h0);
    arst_n = 1'b1;
    tick(); chk("R9 held edge 1", 32'(core_rst), 32'd1);
    tick(); chk("R9 held edge 2", 32'(core_rst), 32'd1);
    tick(); chk("R9 release core_rst", 32'(core_rst), 32'd0);
    chk("R9 release pc_load", 32'(pc_load), 32'd1);
    tick(); chk("R5 load width after power-up", 32'(pc_load), 32'd0);

    // Table walk: one-cycle causes, single and combined (R1 R2 R3 R6 R8)
    for (int i = 0; i < NV; i++) begin
      {brk_req, wdt_ovf, op_trap, supply_low} = TBL[i][23:20];
      tick();
      brk_req = 1'b0; wdt_ovf = 1'b0; op_trap = 1'b0; supply_low = 1'b0;
      chk("R1 core_rst after cause", 32'(core_rst), 32'd1);
      chk("R3 R8 recorded cause", 32'(cause), 32'(TBL[i][3:0]));
      chk("R5 no strobe during reset", 32'(pc_load), 32'd0);
      tick();
      chk("R1 one-cycle reset", 32'(core_rst), 32'd0);
      chk("R5 strobe on release", 32'(pc_load), 32'd1);
      chk("R2 start vector", 32'(start_vec), 32'(TBL[i][19:4]));
      tick();
      chk("R5 strobe one cycle", 32'(pc_load), 32'd0);
      chk("R8 cause held", 32'(cause), 32'(TBL[i][3:0]));
      tick();
    end

    // R4 pin synchroniser latency and hold
    ext_rst_n = 1'b0;
    tick(); chk("R4 not yet edge 1", 32'(core_rst), 32'd0);
    tick(); chk("R4 not yet edge 2", 32'(core_rst), 32'd0);
    tick(); chk("R4 asserted edge 3", 32'(core_rst), 32'd1);
    chk("R8 pin cause", 32'(cause), 32'b0001);
    // R3 pulse cause during held pin reset
    brk_req = 1'b1; wdt_ovf = 1'b1;
    tick(); brk_req = 1'b0; wdt_ovf = 1'b0;
    chk("R3 pin keeps priority", 32'(cause), 32'b0001);
    for (int k = 0; k < 4; k++) begin
      tick(); chk("R4 held while pin low", 32'(core_rst), 32'd1);
    end
    ext_rst_n = 1'b1;
    tick(); chk("R5 release edge 1", 32'(core_rst), 32'd1);
    tick(); chk("R5 release edge 2", 32'(core_rst), 32'd1);
    tick(); chk("R5 release edge 3", 32'(core_rst), 32'd0);
    chk("R5 strobe after pin", 32'(pc_load), 32'd1);
    chk("R2 pin vector", 32'(start_vec), 32'h0000);
    tick();

    // R6 supply-low held several cycles
    op_trap = 1'b1; tick(); op_trap = 1'b0; tick(); tick();
    supply_low = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R6 held by supply-low", 32'(core_rst), 32'd1);
    end
    supply_low = 1'b0;
    tick(); chk("R6 release", 32'(core_rst), 32'd0);
    chk("R6 strobe", 32'(pc_load), 32'd1);
    chk("R6 vector 0", 32'(start_vec), 32'h0000);
    tick();

    // R7 supply-low ignored in stop mode; prior record from a trap
    op_trap = 1'b1; tick(); op_trap = 1'b0; tick(); tick();
    stop_mode = 1'b1; supply_low = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7 no reset in stop", 32'(core_rst), 32'd0);
      chk("R7 no strobe in stop", 32'(pc_load), 32'd0);
    end
    chk("R7 cause untouched", 32'(cause), 32'b1000);
    chk("R7 vector untouched", 32'(start_vec), 32'h0006);
    supply_low = 1'b0; stop_mode = 1'b0;
    tick(); tick();

    finish_run();
  end
endmodule